// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces, one per accepted beat, the column addresses that a synchronous DRAM visits during a single read or write burst. A memory controller or a behavioural memory model drives a start strobe together with the 8-bit column that came with the access command, a burst length code and a wrap type. The block then streams the column of every data beat in order, and it marks the final beat. Such a consumer can therefore tell which stored word belongs to each data beat without knowing the ordering rules itself.

The output is a valid/ready stream. A beat is transferred on a rising clock edge when `beat_valid` and `beat_ready` are both high. While `beat_ready` is low, the current beat, its column and its last flag stay unchanged, and the sequence does not advance. `beat_valid` does not depend on `beat_ready`. A start strobe needs no handshake. It always takes effect on the edge where it is sampled and discards whatever burst was in progress.

Two settings are illegal: interleaved wrap combined with full-page length, and any reserved length code. A start strobe with either setting yields a one-cycle error pulse and no beats.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `beat_valid` and `cfg_err` are low.
- R2: A start strobe sampled high on a clock edge with a legal setting makes `beat_valid` high on the next cycle, with `beat_col` equal to the sampled `start_col` (beat 0).
- R3: Length code 0, 1, 2 and 3 selects a burst of 1, 2, 4 and 8 beats. With sequential wrap (`wrap_ilv`=0), beat i holds the upper column bits at their start value, and its low log2(BL) bits equal the start's low bits plus i, modulo BL.
- R4: With interleaved wrap (`wrap_ilv`=1), beat i is the start column with its low log2(BL) bits XORed with i.
- R5: A burst of length 1 gives exactly one beat, with `beat_last` high.
- R6: Length code 7 with sequential wrap gives a full-page burst of 256 beats. Beat i is (start+i) mod 256, and `beat_last` is high only on the 256th beat.
- R7: A start strobe with length code 7 and `wrap_ilv`=1, or with a reserved length code 4, 5 or 6, drives `cfg_err` high for exactly the next cycle and produces no beat. Any burst in progress is cancelled.
- R8: `beat_last` is high only on the final beat of a burst. After that beat is accepted, `beat_valid` goes low.
- R9: While `beat_valid` is high and `beat_ready` is low, `beat_col` and `beat_last` hold, and no beat is skipped.
- R10: A start strobe during a burst restarts the sequence from the new start column and setting on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Burst start strobe |
| start_col | input | 8 | First column of the burst |
| len_code | input | 3 | Burst length code: 0..3 give 1/2/4/8 beats, 7 gives full page, 4..6 are reserved |
| wrap_ilv | input | 1 | Wrap type: 0 sequential, 1 interleaved |
| beat_valid | output | 1 | A beat column is presented |
| beat_ready | input | 1 | Consumer accepts the presented beat |
| beat_col | output | 8 | Column of the current beat |
| beat_last | output | 1 | Current beat is the last of the burst |
| cfg_err | output | 1 | One-cycle pulse after a start strobe with an illegal setting |

## Verification
The bench uses start columns whose low bits sit near the wrap point. A sequencer that carries into the upper bits in sequential mode, or that adds instead of XORing in interleaved mode, therefore produces wrong columns before the burst ends. The full-page burst starts high in the page, so a design that stops at the top column, or that raises the last flag at 255 beats, is caught. The bench stalls the consumer in mid-burst, which exposes a sequence that advances without a handshake. It also restarts one burst while another is in progress and sends illegal settings. These cases catch a design that finishes the old burst, or one that emits beats or a long error signal for a bad setting.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int LEN_W = 3;
  typedef logic [LEN_W-1:0] len_code_t;
  localparam len_code_t LEN_ONE   = 3'd0;
  localparam len_code_t LEN_TWO   = 3'd1;
  localparam len_code_t LEN_FOUR  = 3'd2;
  localparam len_code_t LEN_EIGHT = 3'd3;
  localparam len_code_t LEN_PAGE  = 3'd7;
endpackage

// File: rtl/bcs_cfg_decode.sv
module bcs_cfg_decode
  import bcs_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  len_code_t        len_code,
  input  logic             wrap_ilv,
  output logic [COL_W-1:0] wrap_mask,
  output logic             bad_cfg
);
  always_comb begin
    wrap_mask = '0;
    bad_cfg   = 1'b0;
    case (len_code)
      LEN_ONE, LEN_TWO, LEN_FOUR, LEN_EIGHT:
        wrap_mask = COL_W'((32'd1 << len_code) - 32'd1);
      LEN_PAGE: begin
        wrap_mask = '1;
        bad_cfg   = wrap_ilv;
      end
      default: bad_cfg = 1'b1;
    endcase
  end
endmodule

// File: rtl/bcs_beat_ctr.sv
module bcs_beat_ctr #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             kill,
  input  logic [COL_W-1:0] mask_in,
  input  logic             ready,
  output logic             valid,
  output logic [COL_W-1:0] idx,
  output logic [COL_W-1:0] mask_q,
  output logic             last
);
  assign last = (idx == mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      idx    <= '0;
      mask_q <= '0;
    end else if (load) begin
      valid  <= 1'b1;
      idx    <= '0;
      mask_q <= mask_in;
    end else if (kill) begin
      valid <= 1'b0;
    end else if (valid && ready) begin
      if (last) valid <= 1'b0;
      else      idx   <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/bcs_addr_map.sv
module bcs_addr_map #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic             ilv,
  input  logic [COL_W-1:0] mask,
  input  logic [COL_W-1:0] idx,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] seq_col;
  logic [COL_W-1:0] ilv_col;
  logic [COL_W-1:0] sum;

  assign sum     = base + idx;
  assign seq_col = (base & ~mask) | (sum & mask);
  assign ilv_col = base ^ (idx & mask);
  assign col     = ilv ? ilv_col : seq_col;
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [LEN_W-1:0] len_code,
  input  logic             wrap_ilv,
  output logic             beat_valid,
  input  logic             beat_ready,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_last,
  output logic             cfg_err
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_bad;
  logic [COL_W-1:0] base_q;
  logic             ilv_q;
  logic [COL_W-1:0] idx;
  logic [COL_W-1:0] mask_q;
  logic             load;
  logic             kill;

  bcs_cfg_decode #(.COL_W(COL_W)) u_dec (
    .len_code (len_code),
    .wrap_ilv (wrap_ilv),
    .wrap_mask(dec_mask),
    .bad_cfg  (dec_bad)
  );

  assign load = start && !dec_bad;
  assign kill = start && dec_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      ilv_q   <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      cfg_err <= kill;
      if (load) begin
        base_q <= start_col;
        ilv_q  <= wrap_ilv;
      end
    end
  end

  bcs_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .kill   (kill),
    .mask_in(dec_mask),
    .ready  (beat_ready),
    .valid  (beat_valid),
    .idx    (idx),
    .mask_q (mask_q),
    .last   (beat_last)
  );

  bcs_addr_map #(.COL_W(COL_W)) u_map (
    .base(base_q),
    .ilv (ilv_q),
    .mask(mask_q),
    .idx (idx),
    .col (beat_col)
  );
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic [2:0]       len_code,
  input logic             wrap_ilv,
  input logic             beat_valid,
  input logic             beat_ready,
  input logic [COL_W-1:0] beat_col,
  input logic             beat_last,
  input logic             cfg_err
);
  logic illegal;
  assign illegal = (len_code inside {3'd4, 3'd5, 3'd6}) || (len_code == 3'd7 && wrap_ilv);

  p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !illegal |=> beat_valid && beat_col == $past(start_col) && !cfg_err);

  p_bad_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start && illegal |=> cfg_err && !beat_valid);

  p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !cfg_err);

  p_end_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && beat_last && !start |=> !beat_valid);

  p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready && !start |=> beat_valid && $stable(beat_col) && $stable(beat_last));

  p_idle_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_valid && !start |=> !beat_valid);
endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W)) u_bcs_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .start_col (start_col),
  .len_code  (len_code),
  .wrap_ilv  (wrap_ilv),
  .beat_valid(beat_valid),
  .beat_ready(beat_ready),
  .beat_col  (beat_col),
  .beat_last (beat_last),
  .cfg_err   (cfg_err)
);

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] start_col = '0;
  logic [2:0] len_code = '0;
  logic       wrap_ilv = 1'b0;
  logic       beat_valid;
  logic       beat_ready = 1'b1;
  logic [7:0] beat_col;
  logic       beat_last;
  logic       cfg_err;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  burst_col_seq u_burst_col_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .len_code(len_code), .wrap_ilv(wrap_ilv), .beat_valid(beat_valid),
    .beat_ready(beat_ready), .beat_col(beat_col), .beat_last(beat_last),
    .cfg_err(cfg_err)
  );

  function automatic int bl_of(input logic [2:0] len);
    return (len == 3'd7) ? 256 : (1 << len);
  endfunction

  function automatic logic [7:0] exp_col(input logic [7:0] base, input logic [2:0] len,
                                         input logic ilv, input int i);
    logic [7:0] m;
    logic [7:0] s;
    m = 8'(bl_of(len) - 1);
    s = base + 8'(i);
    if (ilv) return base ^ (8'(i) & m);
    return (base & ~m) | (s & m);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Raises start at the current falling edge; returns at the next falling edge.
  task automatic kick(input logic [7:0] col, input logic [2:0] len, input logic ilv);
    start = 1'b1; start_col = col; len_code = len; wrap_ilv = ilv;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Checks n accepted beats from the current falling edge; stall inserts ready-low cycles.
  task automatic drain(input string req, input logic [7:0] col, input logic [2:0] len,
                       input logic ilv, input int n, input bit stall);
    int k = 0;
    int cyc = 0;
    logic [7:0] held;
    while (k < n) begin
      check(req, {31'd0, beat_valid}, 32'd1);
      check(req, {24'd0, beat_col}, {24'd0, exp_col(col, len, ilv, k)});
      check(req, {31'd0, beat_last}, {31'd0, (k == bl_of(len) - 1)});
      beat_ready = stall ? (cyc % 3 != 1) : 1'b1;
      held = beat_col;
      if (beat_ready) k++;
      cyc++;
      @(negedge clk);
      if (!beat_ready) check("R9 hold", {24'd0, beat_col}, {24'd0, held});
    end
    beat_ready = 1'b1;
    if (n == bl_of(len)) check({req, " R8 end"}, {31'd0, beat_valid}, 32'd0);
  endtask

  task automatic t_reset;
    check("R1 valid", {31'd0, beat_valid}, 32'd0);
    check("R1 err", {31'd0, cfg_err}, 32'd0);
  endtask

  task automatic t_seq;
    kick(8'h3E, 3'd2, 1'b0); drain("R3 R2 seq4", 8'h3E, 3'd2, 1'b0, 4, 1'b0);
    kick(8'hFD, 3'd3, 1'b0); drain("R3 seq8", 8'hFD, 3'd3, 1'b0, 8, 1'b0);
    kick(8'h41, 3'd1, 1'b0); drain("R3 seq2", 8'h41, 3'd1, 1'b0, 2, 1'b0);
  endtask

  task automatic t_ilv;
    kick(8'h35, 3'd3, 1'b1); drain("R4 ilv8", 8'h35, 3'd3, 1'b1, 8, 1'b0);
    kick(8'hA6, 3'd2, 1'b1); drain("R4 ilv4", 8'hA6, 3'd2, 1'b1, 4, 1'b0);
  endtask

  task automatic t_single;
    kick(8'h77, 3'd0, 1'b1); drain("R5 bl1", 8'h77, 3'd0, 1'b1, 1, 1'b0);
  endtask

  task automatic t_page;
    kick(8'hF0, 3'd7, 1'b0); drain("R6 page", 8'hF0, 3'd7, 1'b0, 256, 1'b0);
  endtask

  task automatic t_stall;
    kick(8'h1D, 3'd3, 1'b0); drain("R9 stall", 8'h1D, 3'd3, 1'b0, 8, 1'b1);
  endtask

  task automatic t_bad(input logic [2:0] len, input logic ilv);
    kick(8'h20, 3'd3, 1'b0); drain("R10 pre", 8'h20, 3'd3, 1'b0, 2, 1'b0);
    kick(8'h55, len, ilv);
    check("R7 err", {31'd0, cfg_err}, 32'd1);
    check("R7 no beat", {31'd0, beat_valid}, 32'd0);
    @(negedge clk);
    check("R7 pulse", {31'd0, cfg_err}, 32'd0);
    check("R7 still idle", {31'd0, beat_valid}, 32'd0);
  endtask

  task automatic t_restart;
    kick(8'h10, 3'd3, 1'b0); drain("R10 first", 8'h10, 3'd3, 1'b0, 3, 1'b0);
    kick(8'h80, 3'd2, 1'b1); drain("R10 restart", 8'h80, 3'd2, 1'b1, 4, 1'b0);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_seq();
    t_ilv();
    t_single();
    t_page();
    t_stall();
    t_bad(3'd7, 1'b1);
    t_bad(3'd5, 1'b0);
    t_restart();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule